// File: doc/BRIEF.md
# Time-Slot Switch Core

This block is the per-slot switching datapath of a four-stream, 128-channel time-slot interchange. One slot is handled per clock. The slot order is channel-major: slot index = channel*4 + stream, so all four streams of a channel arrive on consecutive clocks. Each clock, the incoming byte for the current slot is stored in a data memory. The same clock reads the connection word for that slot. The word decides three things for the outgoing byte: its source, whether its driver is enabled, and whether it is fed back into the data memory in place of the received byte.

The data memory has three banks that rotate on every frame pulse. Each connection word picks its own latency. Constant delay returns a byte exactly two frames after it was stored. Variable delay takes the byte from the current frame when its source slot has already passed, and from the previous frame otherwise. A simple write port loads the connection memory, and a write takes effect from the next slot on.

Top module: `tsi_switch_core`

## Requirements
- R1: While reset is asserted and right after it, `tx_oe` and `tx_data` are 0.
- R2: A high `frame_sync` marks slot 0 in that clock. Each following clock advances the slot by one, in the order slot = channel*4 + stream. Every frame pulse rotates the three data-memory banks.
- R3: Connection word bits are [12] enable, [11] processor mode, [10] variable delay (1 = variable), [9] loopback, [8:7] source stream, [6:0] source channel. When bit 11 is 1, the output byte is word[7:0].
- R4: When bit 11 is 0, the output byte is the byte stored for source slot channel*4 + stream from the fields [6:0] and [8:7].
- R5: With bit 10 at 0, the byte read is the one stored in that source slot two frames before the current frame.
- R6: With bit 10 at 1, the byte read comes from the current frame if the source slot index is lower than the current slot index. Otherwise it comes from the previous frame.
- R7: When `out_force_en` and `standby_en` are both 0, `tx_oe` is 0 whatever the connection word holds.
- R8: When either `out_force_en` or `standby_en` is 1, `tx_oe` equals bit 12 of the slot's connection word.
- R9: When bit 9 is 1, the data memory stores the slot's output byte instead of `rx_data` for that stream and channel. This holds whether or not the driver is enabled.
- R10: A connection memory write in a clock is seen by slots from the next clock on, and the frames keep running during the write.
- R11: `tx_data`, `tx_oe`, `tx_stream` and `tx_chan` for a slot appear one clock after that slot's input clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_sync | input | 1 | Frame pulse, high during slot 0 |
| rx_data | input | 8 | Received byte for the current slot |
| out_force_en | input | 1 | High hands output enables to the per-slot bits |
| standby_en | input | 1 | Global enable used while out_force_en is low |
| cm_we | input | 1 | Connection memory write strobe |
| cm_addr | input | 9 | Connection memory slot index (channel*4+stream) |
| cm_wdata | input | 13 | Connection word to write |
| tx_data | output | 8 | Output byte |
| tx_oe | output | 1 | Output driver enable for the byte |
| tx_stream | output | 2 | Stream of the byte on tx_data |
| tx_chan | output | 7 | Channel of the byte on tx_data |

## Verification
The assertions take for granted that `frame_sync` arrives exactly every 512 clocks. This keeps the bank rotation in step with the slot counter, and it means the current slot decides the delay rule. The bench always pulses on slot 0 of every frame and never mid-frame. Before any per-slot enable or data is judged, it loads the whole connection memory with the output gate closed. Its reference model treats bytes from frames that were never stored as unknown and does not compare them.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  localparam int NSTREAM = 4;
  localparam int NCHAN   = 128;
  localparam int BYTE_W  = 8;
  localparam int NBANK   = 3;
  localparam int ST_W    = $clog2(NSTREAM);
  localparam int CH_W    = $clog2(NCHAN);
  localparam int SLOT_W  = ST_W + CH_W;
  localparam int NSLOT   = NSTREAM * NCHAN;
  localparam int BANK_W  = $clog2(NBANK);
  localparam int CW_W    = 4 + ST_W + CH_W;

  typedef struct packed {
    logic            oe;
    logic            pc;
    logic            vdly;
    logic            lb;
    logic [ST_W-1:0] sa;
    logic [CH_W-1:0] ca;
  } conn_word_t;

  // slot index = channel * NSTREAM + stream
  function automatic logic [SLOT_W-1:0] slot_of(logic [ST_W-1:0] st, logic [CH_W-1:0] ch);
    return {ch, st};
  endfunction

  function automatic logic [BANK_W-1:0] bank_back(logic [BANK_W-1:0] b, int unsigned n);
    int unsigned t;
    t = (int'(unsigned'(b)) + NBANK - n) % NBANK;
    return BANK_W'(t);
  endfunction

  function automatic logic [BANK_W-1:0] bank_next(logic [BANK_W-1:0] b);
    return bank_back(b, NBANK - 1);
  endfunction

  function automatic logic source_passed(logic [SLOT_W-1:0] src, logic [SLOT_W-1:0] cur);
    return src < cur;
  endfunction

  function automatic logic gate_enable(logic force_en, logic standby, logic slot_oe);
    return (force_en | standby) & slot_oe;
  endfunction
endpackage

// File: rtl/tsi_frame_timer.sv
module tsi_frame_timer
  import tsi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_sync,
  output logic [SLOT_W-1:0] cur_slot,
  output logic [BANK_W-1:0] cur_bank
);
  logic [SLOT_W-1:0] slot_q;
  logic [BANK_W-1:0] bank_q;
  logic              ev_wrap;

  assign cur_slot = frame_sync ? '0 : slot_q;
  assign cur_bank = frame_sync ? bank_next(bank_q) : bank_q;
  assign ev_wrap  = (cur_slot == SLOT_W'(NSLOT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      bank_q <= '0;
    end else begin
      slot_q <= ev_wrap ? '0 : cur_slot + SLOT_W'(1);
      bank_q <= cur_bank;
    end
  end

  AST_SYNC_RESTART: assert property (@(posedge clk) disable iff (!rst_n) frame_sync |=> slot_q == SLOT_W'(1)); // R2
  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !frame_sync |=> bank_q == $past(bank_q)); // R2
  AST_BANK_TURN: assert property (@(posedge clk) disable iff (!rst_n) frame_sync |=> bank_q != $past(bank_q)); // R2
  AST_BANK_RANGE: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> bank_q < BANK_W'(NBANK)); // R2
endmodule

// File: rtl/tsi_conn_mem.sv
module tsi_conn_mem
  import tsi_pkg::*;
(
  input  logic              clk,
  input  logic              we,
  input  logic [SLOT_W-1:0] waddr,
  input  logic [CW_W-1:0]   wdata,
  input  logic [SLOT_W-1:0] raddr,
  output logic [CW_W-1:0]   rdata
);
  logic [CW_W-1:0] mem [NSLOT];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/tsi_data_mem.sv
module tsi_data_mem
  import tsi_pkg::*;
(
  input  logic              clk,
  input  logic [BANK_W-1:0] wbank,
  input  logic [SLOT_W-1:0] waddr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [BANK_W-1:0] rbank,
  input  logic [SLOT_W-1:0] raddr,
  output logic [BYTE_W-1:0] rdata
);
  logic [BYTE_W-1:0] bank_rd [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [BYTE_W-1:0] mem [NSLOT];
    always_ff @(posedge clk) begin
      if (wbank == BANK_W'(b)) mem[waddr] <= wdata;
    end
    assign bank_rd[b] = mem[raddr];
  end

  always_comb begin
    rdata = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (rbank == BANK_W'(b)) rdata = bank_rd[b];
    end
  end
endmodule

// File: rtl/tsi_slot_decide.sv
module tsi_slot_decide
  import tsi_pkg::*;
(
  input  conn_word_t        word,
  input  logic [SLOT_W-1:0] cur_slot,
  input  logic [BANK_W-1:0] cur_bank,
  input  logic              out_force_en,
  input  logic              standby_en,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic [BYTE_W-1:0] mem_byte,
  output logic [BANK_W-1:0] rd_bank,
  output logic [SLOT_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] out_byte,
  output logic              out_en,
  output logic              store_byte_sel_tx,
  output logic [BYTE_W-1:0] store_byte
);
  logic [CW_W-1:0] word_bits;

  assign word_bits = word;
  assign rd_addr   = slot_of(word.sa, word.ca);

  always_comb begin
    if (!word.vdly)                          rd_bank = bank_back(cur_bank, 2);
    else if (source_passed(rd_addr, cur_slot)) rd_bank = cur_bank;
    else                                     rd_bank = bank_back(cur_bank, 1);
  end

  assign out_byte          = word.pc ? word_bits[BYTE_W-1:0] : mem_byte;
  assign out_en            = gate_enable(out_force_en, standby_en, word.oe);
  assign store_byte_sel_tx = word.lb;
  assign store_byte        = word.lb ? out_byte : rx_byte;
endmodule

// File: rtl/tsi_switch_core.sv
module tsi_switch_core
  import tsi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_sync,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              out_force_en,
  input  logic              standby_en,
  input  logic              cm_we,
  input  logic [SLOT_W-1:0] cm_addr,
  input  logic [CW_W-1:0]   cm_wdata,
  output logic [BYTE_W-1:0] tx_data,
  output logic              tx_oe,
  output logic [ST_W-1:0]   tx_stream,
  output logic [CH_W-1:0]   tx_chan
);
  logic [SLOT_W-1:0] cur_slot;
  logic [BANK_W-1:0] cur_bank;
  logic [CW_W-1:0]   cur_word_raw;
  conn_word_t        cur_word;
  logic [BANK_W-1:0] rd_bank;
  logic [SLOT_W-1:0] rd_addr;
  logic [BYTE_W-1:0] mem_byte;
  logic [BYTE_W-1:0] out_byte;
  logic              out_en;
  logic              ev_loop_store;
  logic [BYTE_W-1:0] store_byte;

  tsi_frame_timer u_timer (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync),
    .cur_slot(cur_slot), .cur_bank(cur_bank)
  );

  tsi_conn_mem u_cmem (
    .clk(clk), .we(cm_we), .waddr(cm_addr), .wdata(cm_wdata),
    .raddr(cur_slot), .rdata(cur_word_raw)
  );

  assign cur_word = conn_word_t'(cur_word_raw);

  tsi_data_mem u_dmem (
    .clk(clk), .wbank(cur_bank), .waddr(cur_slot), .wdata(store_byte),
    .rbank(rd_bank), .raddr(rd_addr), .rdata(mem_byte)
  );

  tsi_slot_decide u_decide (
    .word(cur_word), .cur_slot(cur_slot), .cur_bank(cur_bank),
    .out_force_en(out_force_en), .standby_en(standby_en),
    .rx_byte(rx_data), .mem_byte(mem_byte),
    .rd_bank(rd_bank), .rd_addr(rd_addr), .out_byte(out_byte),
    .out_en(out_en), .store_byte_sel_tx(ev_loop_store), .store_byte(store_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_data   <= '0;
      tx_oe     <= 1'b0;
      tx_stream <= '0;
      tx_chan   <= '0;
    end else begin
      tx_data   <= out_byte;
      tx_oe     <= out_en;
      tx_stream <= cur_slot[ST_W-1:0];
      tx_chan   <= cur_slot[SLOT_W-1:ST_W];
    end
  end

  AST_PROC_BYTE: assert property (@(posedge clk) disable iff (!rst_n) cur_word.pc |=> tx_data == $past(cur_word_raw[BYTE_W-1:0])); // R3
  AST_GATE_CLOSED: assert property (@(posedge clk) disable iff (!rst_n) (!out_force_en && !standby_en) |=> !tx_oe); // R7
  AST_SLOT_OFF: assert property (@(posedge clk) disable iff (!rst_n) !cur_word.oe |=> !tx_oe); // R8
  AST_CONST_BANK: assert property (@(posedge clk) disable iff (!rst_n) (!cur_word.pc && !cur_word.vdly) |-> rd_bank != cur_bank); // R5
  AST_LOOP_SRC: assert property (@(posedge clk) disable iff (!rst_n) (ev_loop_store && cur_word.pc) |=> tx_data == $past(store_byte)); // R9
  AST_SLOT_REPORT: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> {tx_chan, tx_stream} == $past(cur_slot)); // R11
endmodule

// File: tb/tsi_switch_core_bench.sv
module tsi_switch_core_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_sync = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        out_force_en = 1'b0;
  logic        standby_en = 1'b0;
  logic        cm_we = 1'b0;
  logic [8:0]  cm_addr = '0;
  logic [12:0] cm_wdata = '0;
  logic [7:0]  tx_data;
  logic        tx_oe;
  logic [1:0]  tx_stream;
  logic [6:0]  tx_chan;

  always #10 clk = ~clk;

  tsi_switch_core u_tsi_switch_core (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .rx_data(rx_data),
    .out_force_en(out_force_en), .standby_en(standby_en),
    .cm_we(cm_we), .cm_addr(cm_addr), .cm_wdata(cm_wdata),
    .tx_data(tx_data), .tx_oe(tx_oe), .tx_stream(tx_stream), .tx_chan(tx_chan)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [12:0] cm_model [512];
  bit          cm_known [512];
  logic [7:0]  hist [int];
  bit          loop_made [int];
  int frame_no = -1;
  int slot_no = 511;
  string extra = "";

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (frame %0d slot %0d)", tag, act, exp, frame_no, slot_no);
    end
  endtask

  // called at a negative edge; one slot
  task automatic run_slot(bit sync, logic [7:0] rx, bit we, int waddr, logic [12:0] wword);
    logic [12:0] w;
    int s, f, src, key, wkey;
    bit known, from_loop, en_exp;
    logic [7:0] val;
    string dtag;
    frame_sync = sync; rx_data = rx;
    cm_we = we; cm_addr = 9'(waddr); cm_wdata = wword;
    s = sync ? 0 : (slot_no + 1) % 512;
    f = sync ? frame_no + 1 : frame_no;
    w = cm_model[s];
    src = int'(w[6:0]) * 4 + int'(w[8:7]);
    from_loop = 0; val = '0; known = 0;
    if (w[11]) begin
      known = 1; val = w[7:0]; dtag = "R3";
    end else begin
      if (w[10]) begin
        key = ((src < s) ? f : f - 1) * 512 + src; dtag = "R4 R6";
      end else begin
        key = (f - 2) * 512 + src; dtag = "R4 R5";
      end
      known = hist.exists(key);
      if (known) begin val = hist[key]; from_loop = loop_made[key]; end
      if (from_loop) dtag = "R9";
    end
    en_exp = (out_force_en | standby_en) & w[12];
    @(posedge clk);
    wkey = f * 512 + s;
    if (w[9]) begin
      if (known && cm_known[s]) begin hist[wkey] = val; loop_made[wkey] = 1; end
      else if (hist.exists(wkey)) hist.delete(wkey);
    end else begin
      hist[wkey] = rx; loop_made[wkey] = 0;
    end
    if (we) begin cm_model[waddr] = wword; cm_known[waddr] = 1; end
    slot_no = s; frame_no = f;
    @(negedge clk);
    check("R2 R11", {23'd0, tx_chan, tx_stream}, s);
    if (!out_force_en && !standby_en) check({"R7", extra}, int'(tx_oe), 0);
    else if (cm_known[s]) check({"R8", extra}, int'(tx_oe), int'(en_exp));
    if (known && cm_known[s]) check({dtag, extra}, int'(tx_data), int'(val));
  endtask

  function automatic logic [12:0] gen_word(int kind, int addr);
    logic [8:0] r;
    r = 9'($urandom);
    if (kind == 2 && addr == 3) return {4'b1101, 9'h0A5};
    if (kind == 2 && addr == 10) return {4'b1000, 2'b11, 7'd0};
    case (kind)
      0: return {4'b1000, r};
      1: return {4'b1010, r};
      default: return 13'($urandom);
    endcase
  endfunction

  // kind < 0: no connection memory writes
  task automatic run_frame(int kind, int standby_from);
    for (int i = 0; i < 512; i++) begin
      if (standby_from >= 0) standby_en = (i >= standby_from);
      if (kind >= 0) run_slot(i == 0, 8'($urandom), 1'b1, i, gen_word(kind, i));
      else run_slot(i == 0, 8'($urandom), 1'b0, 0, '0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 512; i++) begin cm_known[i] = 0; cm_model[i] = '0; end
    void'($urandom(7));
    repeat (3) @(negedge clk);
    check("R1", int'(tx_oe), 0);
    check("R1", int'(tx_data), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", int'(tx_oe), 0);
    // load all words with the gate closed
    out_force_en = 0; standby_en = 0;
    run_frame(0, -1);
    out_force_en = 1;
    run_frame(-1, -1); run_frame(-1, -1); run_frame(-1, -1);
    extra = " R10";
    run_frame(1, -1);
    extra = "";
    run_frame(-1, -1); run_frame(-1, -1);
    out_force_en = 0; standby_en = 1;
    extra = " R10";
    run_frame(2, -1);
    extra = "";
    run_frame(-1, -1);
    run_frame(-1, 100);
    out_force_en = 1; standby_en = 0;
    run_frame(-1, -1); run_frame(-1, -1);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule